// File: doc/BRIEF.md
# Ten-bit timer counter with compare

This block is a 10-bit up-counter controlled through a small byte-wide register interface. A control register selects the count tick, the pause and on/off state and a 3-bit period value P. A second control register holds a clear-select bit and the two sticky match flags. The 10-bit count is read through a low and a high byte. Reading the low byte freezes the upper count bits in a shadow, so a following high-byte read gives a consistent value.

The count tick comes from one of several single-cycle enables in the one system clock domain:
- the system clock itself;
- a free-running divide-by-4 of the system clock;
- a divide-by-16 or divide-by-64 of a high-clock enable input;
- a time-base strobe;
- a rising or falling edge on an asynchronous pin, after a two-flop synchroniser.

One select code is reserved and stops counting.

Turning the timer on clears the count. Turning it off or pausing it keeps the count.

On a tick, the count is compared against compare value A and against the period boundary given by P. A match sets a flag. Depending on the clear-select bit, the counter restarts from zero on one of the two matches.

Top module: `tmr10_top`

## Requirements
- R1: After reset, every register reads 0 and the count is 0.
- R2: Address map:
  - 0: control 0.
  - 1: control 1.
  - 2: count low byte.
  - 3: count high byte, bits 1:0 used.
  - 4: compare A low byte.
  - 5: compare A high byte, bits 1:0 used.

  Unused bits read 0. Compare A is read/write. Writes to the count bytes are ignored.
- R3: Control 0 bits 6:4 select the tick:
  - 001: every system clock cycle.
  - 000: every 4th system clock cycle.
  - 010: every 16th high-clock enable.
  - 011: every 64th high-clock enable.
  - 100: each time-base strobe cycle.
- R4: Select 110 counts rising edges of the pin and 111 counts falling edges, after a two-flop synchroniser.
- R5: Select 101 is reserved and the count does not advance.
- R6: While control 0 bit 7 (pause) is 1 the count holds. Clearing it resumes counting from the held value.
- R7: Control 0 bit 3 is the on bit:
  - A write that takes it from 0 to 1 clears the count to 0.
  - While it is 0 the count keeps its value.
- R8: On a tick where the count equals compare A, the A flag (control 1 bit 6) is set. With control 1 bit 0 = 1 the count then returns to 0, giving a period of A+1 ticks.
- R9: With control 1 bit 0 = 0, the count returns to 0 after P×128 ticks, where P is control 0 bits 2:0. P = 0 means 1024 ticks. The P flag (control 1 bit 7) is set on that tick.
- R10: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R11: Reading the count low byte latches count bits 9:8. The high byte returns the latched bits until the next low-byte read.
- R12: From 1023 the count always wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (latches shadow on low-byte read) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| hclk_en_i | input | 1 | High-clock enable pulses |
| tb_tick_i | input | 1 | Time-base strobe |
| pin_i | input | 1 | Asynchronous external count pin |
| flag_a_o | output | 1 | Compare-A match flag |
| flag_p_o | output | 1 | Period match flag |

## Verification
The assertions assume the following about the inputs:
- Register strobes are sampled only on the clock edge.
- The match pulses reaching the flag logic come only from the counter.
- The pin may change at any time but stays at each level longer than the synchroniser latency.

The stimulus drives the bus and strobes on the falling edge, holds the pin for three cycles per level, and changes control fields only through whole register writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 10;
  localparam int P_W    = 3;
  localparam int HI_W   = CNT_W - 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNTL  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNTH  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMPL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMPH  = 3'd5;

  typedef enum logic [2:0] {
    CK_SYS4 = 3'b000,
    CK_SYS  = 3'b001,
    CK_H16  = 3'b010,
    CK_H64  = 3'b011,
    CK_TB   = 3'b100,
    CK_RSVD = 3'b101,
    CK_PINR = 3'b110,
    CK_PINF = 3'b111
  } ck_sel_e;

  typedef struct packed {
    logic           pause;
    ck_sel_e        ck;
    logic           on;
    logic [P_W-1:0] per;
  } ctrl0_t;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
  import tmr_pkg::*;
#(
  parameter int SYS_DIV_LOG2 = 2,
  parameter int H_DIV1_LOG2  = 4,
  parameter int H_DIV2_LOG2  = 6,
  parameter int SYNC_STAGES  = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ck_sel_e sel_i,
  input  logic    hclk_en_i,
  input  logic    tb_tick_i,
  input  logic    pin_i,
  output logic    tick_o
);
  logic [SYS_DIV_LOG2-1:0] sys_pre_q;
  logic [H_DIV2_LOG2-1:0]  h_pre_q;
  logic [SYNC_STAGES-1:0]  sync_q;
  logic                    pin_d_q;
  logic                    pin_s;
  logic                    t_sys4, t_h16, t_h64, t_rise, t_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_pre_q <= '0;
      h_pre_q   <= '0;
    end else begin
      sys_pre_q <= sys_pre_q + 1'b1;
      if (hclk_en_i) h_pre_q <= h_pre_q + 1'b1;
    end
  end

  assign t_sys4 = &sys_pre_q;
  assign t_h16  = hclk_en_i & (&h_pre_q[H_DIV1_LOG2-1:0]);
  assign t_h64  = hclk_en_i & (&h_pre_q);

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= pin_i;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_d_q <= 1'b0;
    else pin_d_q <= pin_s;
  end

  assign t_rise = pin_s & ~pin_d_q;
  assign t_fall = ~pin_s & pin_d_q;

  always_comb begin
    unique case (sel_i)
      CK_SYS4: tick_o = t_sys4;
      CK_SYS:  tick_o = 1'b1;
      CK_H16:  tick_o = t_h16;
      CK_H64:  tick_o = t_h64;
      CK_TB:   tick_o = tb_tick_i;
      CK_PINR: tick_o = t_rise;
      CK_PINF: tick_o = t_fall;
      default: tick_o = 1'b0;
    endcase
  end

  // R3: divided system tick is never back to back
  p_sys4_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == CK_SYS4) && tick_o |=> !(tick_o && sel_i == CK_SYS4));
  // R5
  p_reserved_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == CK_RSVD) |-> !tick_o);
  // R4: pin edges yield single-cycle ticks
  p_pin_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == CK_PINR) && tick_o |=> !t_rise);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_src_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] cmpa_i,
  input  logic [P_W-1:0]   per_i,
  input  logic             csel_a_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_a_o,
  output logic             hit_p_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   per_thr;
  logic             tick;
  logic             restart;

  assign tick    = tick_src_i & run_i;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign per_thr = (per_i == '0) ? (CNT_W+1)'(1) << CNT_W
                                 : {1'b0, per_i, {(CNT_W-P_W){1'b0}}};
  assign hit_a_o = tick & (cnt_q == cmpa_i);
  assign hit_p_o = tick & (cnt_inc == per_thr);
  assign restart = csel_a_i ? hit_a_o : hit_p_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (tick) cnt_q <= restart ? '0 : cnt_inc[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;

  // R7
  p_clear_on_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  // R6 / R7: stopped timer holds its count
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !run_i |=> $stable(cnt_q));
  // R12
  p_wrap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && tick_src_i && run_i && (&cnt_q) |=> cnt_q == '0);
  // R8
  p_aclear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && tick_src_i && run_i && csel_a_i && (cnt_q == cmpa_i) |=> cnt_q == '0);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              hit_a_i,
  input  logic              hit_p_i,
  output ctrl0_t            ctrl0_o,
  output logic              csel_a_o,
  output logic [CNT_W-1:0]  cmpa_o,
  output logic              on_rise_o,
  output logic              flag_a_o,
  output logic              flag_p_o
);
  ctrl0_t           ctrl0_q;
  logic             csel_q, flag_a_q, flag_p_q;
  logic [CNT_W-1:0] cmpa_q;
  logic [HI_W-1:0]  shadow_q;
  logic             wr_c0, wr_c1, wr_ml, wr_mh, rd_cl;
  logic             unused_wbits;

  assign wr_c0 = wr_i && addr_i == A_CTRL0;
  assign wr_c1 = wr_i && addr_i == A_CTRL1;
  assign wr_ml = wr_i && addr_i == A_CMPL;
  assign wr_mh = wr_i && addr_i == A_CMPH;
  assign rd_cl = rd_i && addr_i == A_CNTL;
  assign unused_wbits = ^wdata_i[5:1];

  assign on_rise_o = wr_c0 & wdata_i[3] & ~ctrl0_q.on;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl0_q  <= '0;
      csel_q   <= 1'b0;
      flag_a_q <= 1'b0;
      flag_p_q <= 1'b0;
      cmpa_q   <= '0;
      shadow_q <= '0;
    end else begin
      if (wr_c0) ctrl0_q <= ctrl0_t'(wdata_i);
      if (wr_c1) csel_q <= wdata_i[0];
      flag_a_q <= (flag_a_q & ~(wr_c1 & wdata_i[6])) | hit_a_i;
      flag_p_q <= (flag_p_q & ~(wr_c1 & wdata_i[7])) | hit_p_i;
      if (wr_ml) cmpa_q[7:0] <= wdata_i;
      if (wr_mh) cmpa_q[CNT_W-1:8] <= wdata_i[HI_W-1:0];
      if (rd_cl) shadow_q <= cnt_i[CNT_W-1:8];
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL0: rdata_o = ctrl0_q;
      A_CTRL1: rdata_o = {flag_p_q, flag_a_q, 5'b0, csel_q};
      A_CNTL:  rdata_o = cnt_i[7:0];
      A_CNTH:  rdata_o = {{(8-HI_W){1'b0}}, shadow_q};
      A_CMPL:  rdata_o = cmpa_q[7:0];
      A_CMPH:  rdata_o = {{(8-HI_W){1'b0}}, cmpa_q[CNT_W-1:8]};
      default: rdata_o = 8'h00;
    endcase
  end

  assign ctrl0_o  = ctrl0_q;
  assign csel_a_o = csel_q;
  assign cmpa_o   = cmpa_q;
  assign flag_a_o = flag_a_q;
  assign flag_p_o = flag_p_q;

  // R8
  p_flag_a_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_a_i |=> flag_a_q);
  // R9
  p_flag_p_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_p_i |=> flag_p_q);
  // R10
  p_w1c_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_c1 && wdata_i[6] && !hit_a_i |=> !flag_a_q);
  // R11
  p_shadow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cl |=> shadow_q == $past(cnt_i[CNT_W-1:8]));
endmodule

// File: rtl/tmr10_top.sv
module tmr10_top
  import tmr_pkg::*;
#(
  parameter int SYS_DIV_LOG2 = 2,
  parameter int H_DIV1_LOG2  = 4,
  parameter int H_DIV2_LOG2  = 6,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        hclk_en_i,
  input  logic        tb_tick_i,
  input  logic        pin_i,
  output logic        flag_a_o,
  output logic        flag_p_o
);
  ctrl0_t           ctrl0;
  logic             csel_a, on_rise, src_tick, run, hit_a, hit_p;
  logic [CNT_W-1:0] cmpa, cnt;

  assign run = ctrl0.on & ~ctrl0.pause;

  tmr_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .hit_a_i(hit_a), .hit_p_i(hit_p),
    .ctrl0_o(ctrl0), .csel_a_o(csel_a), .cmpa_o(cmpa), .on_rise_o(on_rise),
    .flag_a_o, .flag_p_o
  );

  tmr_tick_sel #(
    .SYS_DIV_LOG2(SYS_DIV_LOG2), .H_DIV1_LOG2(H_DIV1_LOG2),
    .H_DIV2_LOG2(H_DIV2_LOG2), .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk_i, .rst_ni, .sel_i(ctrl0.ck), .hclk_en_i, .tb_tick_i, .pin_i,
    .tick_o(src_tick)
  );

  tmr_counter u_cnt (
    .clk_i, .rst_ni, .tick_src_i(src_tick), .run_i(run), .clr_i(on_rise),
    .cmpa_i(cmpa), .per_i(ctrl0.per), .csel_a_i(csel_a),
    .cnt_o(cnt), .hit_a_o(hit_a), .hit_p_o(hit_p)
  );
endmodule

// File: tb/tmr10_top_test.sv
`timescale 1ns/1ps
module tmr10_top_test;
  logic       clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic       wr = 0, rd = 0, hclk_en = 1, tb_tick = 0, pin = 0;
  logic [7:0] wdata = 0, rdata;
  logic       flag_a, flag_p;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  tmr10_top uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .hclk_en_i(hclk_en),
    .tb_tick_i(tb_tick), .pin_i(pin), .flag_a_o(flag_a), .flag_p_o(flag_p)
  );

  // {ctrl0, ctrl1, cmpa, idle, exp_count, exp_flags{p,a}}
  localparam logic [48:0] VEC [8] = '{
    {8'h18, 8'h00, 10'd1023, 11'd8,    10'd10, 2'b00},  // R3 sys
    {8'h08, 8'h00, 10'd1023, 11'd254,  10'd64, 2'b00},  // R3 /4
    {8'h28, 8'h00, 10'd1023, 11'd254,  10'd16, 2'b00},  // R3 /16
    {8'h38, 8'h00, 10'd1023, 11'd254,  10'd4,  2'b00},  // R3 /64
    {8'h18, 8'h01, 10'd9,    11'd23,   10'd5,  2'b01},  // R8
    {8'h19, 8'h00, 10'd1023, 11'd298,  10'd44, 2'b10},  // R9
    {8'h18, 8'h00, 10'd1023, 11'd1024, 10'd2,  2'b11},  // R12 / R9 P=0
    {8'h58, 8'h00, 10'd1023, 11'd20,   10'd0,  2'b00}   // R5
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_cnt(output int v);
    logic [7:0] lo, hi;
    reg_rd(3'd2, lo); reg_rd(3'd3, hi);
    v = {hi[1:0], lo};
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int v;
    idle(3); rst_n = 1; idle(2);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      reg_rd(3'(a), d); check("R1", d, 0);
    end

    // vector table
    for (int i = 0; i < 8; i++) begin
      logic [48:0] e;
      e = VEC[i];
      reg_wr(3'd0, 8'h00);
      reg_wr(3'd1, e[40:33] | 8'hC0);
      reg_wr(3'd4, e[30:23]);
      reg_wr(3'd5, {6'b0, e[32:31]});
      reg_wr(3'd0, e[48:41]);
      idle(int'(e[22:12]));
      reg_wr(3'd0, e[48:41] & 8'hF7);
      read_cnt(v);
      check($sformatf("R3/R5/R8/R9/R12 count vec%0d", i), v, int'(e[11:2]));
      reg_rd(3'd1, d);
      check($sformatf("R8/R9 flags vec%0d", i), d[7:6], e[1:0]);
    end

    // R2 compare readback, count read-only
    reg_wr(3'd4, 8'hA5); reg_wr(3'd5, 8'hFF);
    reg_rd(3'd4, d); check("R2 cmp lo", d, 8'hA5);
    reg_rd(3'd5, d); check("R2 cmp hi", d, 8'h03);
    reg_wr(3'd2, 8'hFF); reg_wr(3'd3, 8'hFF);
    read_cnt(v); check("R2 count ro", v, 0);
    reg_rd(3'd0, d); check("R2 ctrl0", d, 8'h50);

    // R6 pause, R7 off retain and on clear
    reg_wr(3'd1, 8'hC0);
    reg_wr(3'd0, 8'h00);
    reg_wr(3'd0, 8'h18);
    idle(5);
    reg_wr(3'd0, 8'h98);
    read_cnt(v); check("R6 paused", v, 7);
    idle(10);
    read_cnt(v); check("R6 held", v, 7);
    reg_wr(3'd0, 8'h18);
    idle(3);
    reg_wr(3'd0, 8'h10);
    read_cnt(v); check("R6 resume", v, 12);
    idle(10);
    read_cnt(v); check("R7 off retain", v, 12);
    reg_wr(3'd0, 8'h58);
    read_cnt(v); check("R7 on clears", v, 0);

    // R11 shadow
    reg_wr(3'd0, 8'h00);
    reg_wr(3'd0, 8'h18);
    idle(298);
    reg_wr(3'd0, 8'h10);
    reg_rd(3'd2, d); check("R11 lo", d, 8'h2C);
    reg_rd(3'd3, d); check("R11 hi", d, 1);
    reg_wr(3'd0, 8'h58);
    reg_rd(3'd3, d); check("R11 shadow kept", d, 1);
    reg_rd(3'd2, d); check("R11 lo cleared", d, 0);
    reg_rd(3'd3, d); check("R11 hi relatched", d, 0);
    reg_wr(3'd0, 8'h50);

    // R10 write-one-to-clear
    reg_wr(3'd1, 8'hC1);
    reg_wr(3'd4, 8'h03); reg_wr(3'd5, 8'h00);
    reg_wr(3'd0, 8'h18);
    idle(5);
    reg_wr(3'd0, 8'h10);
    reg_rd(3'd1, d); check("R8 flag A", d, 8'h41);
    check("R8 flag A port", flag_a, 1);
    reg_wr(3'd1, 8'h01);
    reg_rd(3'd1, d); check("R10 write 0 keeps", d, 8'h41);
    reg_wr(3'd1, 8'h41);
    reg_rd(3'd1, d); check("R10 cleared", d, 8'h01);
    check("R10 flag A port", flag_a, 0);
    reg_wr(3'd1, 8'h00);

    // R3 time-base strobe
    reg_wr(3'd0, 8'h48);
    repeat (7) begin
      @(negedge clk); tb_tick = 1;
      @(negedge clk); tb_tick = 0;
      idle(2);
    end
    reg_wr(3'd0, 8'h40);
    read_cnt(v); check("R3 time-base", v, 7);

    // R4 pin rising then falling
    for (int k = 0; k < 2; k++) begin
      reg_wr(3'd0, k == 0 ? 8'h68 : 8'h78);
      repeat (5) begin
        @(negedge clk); pin = 1; idle(3);
        @(negedge clk); pin = 0; idle(3);
      end
      idle(6);
      reg_wr(3'd0, k == 0 ? 8'h60 : 8'h70);
      read_cnt(v); check(k == 0 ? "R4 rising" : "R4 falling", v, 5);
      idle(4);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule